// File: doc/BRIEF.md
# Integer Arithmetic, Logic and Shift Unit with Condition Flags

This block is the execute stage of a small 32-bit core. Each cycle it takes two operands, a five-bit shift amount and a four-bit operation code, and produces a 32-bit result within the same cycle. A clocked condition register beside the datapath holds four flags: negative, zero, carry and overflow. The register loads a new set of flags at a rising clock edge only when the caller asks for flag update. The compare operation is the exception: it always loads the flags.

The operation set covers add, subtract, AND, OR, exclusive-OR, move, move-not, compare, and four ways to shift operand A: left logical, right logical, right arithmetic and rotate right. A destination-write qualifier tells the register file whether the result should be stored. It is low for compare and for the four unused operation codes. There is no state machine. The only sequential element is the flag register. It has two conditions: RESET, entered with a synchronous reset, which clears every flag, and RUN. In RUN, every edge either takes the LOAD transition, when the flag write is enabled, or the HOLD transition, when it is not.

Top module: `dp_alu`

## Requirements
- R1: Operation code 0 (add) gives result = opa + opb modulo 2^32. When flags are written, carry is the unsigned carry out of bit 31 and overflow is set when both operands have the same sign and the result sign differs from it.
- R2: Operation code 1 (subtract) gives result = opa - opb. When flags are written, carry is 1 exactly when opa >= opb unsigned (no borrow), and overflow is set when the operand signs differ and the result sign differs from opa.
- R3: Codes 2, 3 and 4 give opa AND, OR and XOR opb. Code 6 (move) gives opb and code 7 (move-not) gives the bitwise inverse of opb. When flags are written, these operations leave carry and overflow at their previous values.
- R4: Code 8 shifts opa left and code 9 shifts it right with zero fill, both by shamt. When flags are written with a nonzero shamt, carry takes the last bit shifted out: bit 32-shamt for a left shift, bit shamt-1 for a right shift. Overflow is left unchanged.
- R5: Code 10 shifts opa right by shamt and refills with bit 31; for example, 28 shifted right by 2 gives 7. Code 11 rotates opa right by shamt. For both, carry takes bit shamt-1 of opa when shamt is nonzero, and overflow is left unchanged.
- R6: A shift or rotate with shamt = 0 returns opa unchanged and leaves carry unchanged.
- R7: Whenever flags are written, flag_n takes result bit 31 and flag_z is 1 exactly when the result is all zeros. The new flags are visible after the rising edge that ends the operation's cycle.
- R8: For codes 0 to 4 and 6 to 11, the flags load only when upd_flags is 1 at the rising edge. Otherwise all four flags hold their values.
- R9: Code 5 (compare) computes opa - opb and loads all four flags as in R2 and R7, whatever upd_flags is. It drives dest_we low. All other valid codes drive dest_we high.
- R10: A synchronous reset (rst high at a rising edge) clears all four flags to 0, overriding any flag load.
- R11: Codes 12 to 15 are unused. They give result 0 and dest_we low, and never change the flags, even with upd_flags set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset of the flag register, active high |
| op_sel | input | 4 | Operation code (encoding in R1 to R11) |
| upd_flags | input | 1 | Request flag load for this operation |
| opa | input | 32 | First operand, also the value that is shifted |
| opb | input | 32 | Second operand |
| shamt | input | 5 | Shift or rotate amount, 0 to 31 |
| result | output | 32 | Combinational result |
| dest_we | output | 1 | Result should be written to a register |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry flag |
| flag_v | output | 1 | Registered overflow flag |

## Verification
Random operands with random codes over all sixteen values exercise every operation against a bit-serial reference model. Because upd_flags is random, they show whether a flag loads or holds when it should. Directed cases separate the carry and overflow rules:
- equal operands under subtract and compare, which must give zero with carry set;
- sign-boundary sums that overflow in only one direction;
- a negative value under the arithmetic shift, which shows sign fill against zero fill;
- a shift of zero, which must keep the previous carry;
- a flag-setting logic operation that follows an overflowing add, which shows whether overflow is kept.

A reset applied with a flag load pending checks that clearing wins.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_ORR = 4'd3,
        OP_EOR = 4'd4,
        OP_CMP = 4'd5,
        OP_MOV = 4'd6,
        OP_MVN = 4'd7,
        OP_LSL = 4'd8,
        OP_LSR = 4'd9,
        OP_ASR = 4'd10,
        OP_ROR = 4'd11
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_kind_e;

    typedef enum logic [2:0] {
        LG_AND = 3'd0,
        LG_ORR = 3'd1,
        LG_EOR = 3'd2,
        LG_MOV = 3'd3,
        LG_MVN = 3'd4
    } logic_kind_e;

    typedef enum logic [1:0] {
        SRC_ARITH = 2'd0,
        SRC_LOGIC = 2'd1,
        SRC_SHIFT = 2'd2,
        SRC_NONE  = 2'd3
    } res_src_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/dp_alu_addsub.sv
module dp_alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide;

    always_comb begin
        b_eff  = sub_i ? ~b_i : b_i;
        wide   = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
        sum_o  = wide[MSB:0];
        cout_o = wide[WIDTH];
        ovf_o  = (a_i[MSB] == b_eff[MSB]) && (wide[MSB] != a_i[MSB]);
    end

    // R2: x - x is zero with no borrow
    always_comb begin
        if (sub_i && (a_i == b_i)) begin
            p_self_sub_r2: assert (sum_o == '0 && cout_o && !ovf_o);
        end
    end

endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic_kind_e      kind_i,
    output logic [WIDTH-1:0] res_o
);
    always_comb begin
        unique case (kind_i)
            LG_AND:  res_o = a_i & b_i;
            LG_ORR:  res_o = a_i | b_i;
            LG_EOR:  res_o = a_i ^ b_i;
            LG_MOV:  res_o = b_i;
            LG_MVN:  res_o = ~b_i;
            default: res_o = '0;
        endcase
    end

    // R3: move-not is the complement of move
    always_comb begin
        if (kind_i == LG_MVN) begin
            p_mvn_inverse_r3: assert ((res_o ^ b_i) == {WIDTH{1'b1}});
        end
    end

endmodule

// File: rtl/dp_alu_shifter.sv
module dp_alu_shifter
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int SHW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [SHW-1:0]   amt_i,
    input  shift_kind_e      kind_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0]          lsl_t;
    logic [WIDTH:0]          lsr_t;
    logic signed [WIDTH:0]   asr_t;
    logic [2*WIDTH-1:0]      ror_t;

    always_comb begin
        lsl_t = {1'b0, a_i} << amt_i;
        lsr_t = {a_i, 1'b0} >> amt_i;
        asr_t = $signed({a_i, 1'b0}) >>> amt_i;
        ror_t = {a_i, a_i} >> amt_i;
    end

    always_comb begin
        unique case (kind_i)
            SH_LSL: begin
                res_o  = lsl_t[MSB:0];
                cout_o = lsl_t[WIDTH];
            end
            SH_LSR: begin
                res_o  = lsr_t[WIDTH:1];
                cout_o = lsr_t[0];
            end
            SH_ASR: begin
                res_o  = asr_t[WIDTH:1];
                cout_o = asr_t[0];
            end
            SH_ROR: begin
                res_o  = ror_t[MSB:0];
                cout_o = ror_t[MSB];
            end
            default: begin
                res_o  = a_i;
                cout_o = cin_i;
            end
        endcase
        if (amt_i == '0) begin
            cout_o = cin_i;
        end
    end

    // R6: zero amount passes the operand and the carry through
    always_comb begin
        if (amt_i == '0) begin
            p_zero_amt_r6: assert (res_o == a_i && cout_o == cin_i);
        end
    end

    // R5: arithmetic right shift keeps the sign bit
    always_comb begin
        if (kind_i == SH_ASR) begin
            p_sign_fill_r5: assert (res_o[MSB] == a_i[MSB]);
        end
    end

endmodule

// File: rtl/dp_alu_flagreg.sv
module dp_alu_flagreg
    import dp_alu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   we_i,
    input  flags_t d_i,
    output flags_t q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else if (we_i) begin
            q_o <= d_i;
        end
    end

    // R8: HOLD transition keeps every flag
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(we_i)) |-> $stable(q_o));

    // R7: LOAD transition takes the presented flags
    p_load_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(we_i)) |-> (q_o == $past(d_i)));

endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int SHW   = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       op_sel,
    input  logic             upd_flags,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [SHW-1:0]   shamt,
    output logic [WIDTH-1:0] result,
    output logic             dest_we,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_c,
    output logic             flag_v
);
    localparam int MSB = WIDTH - 1;

    alu_op_e     op;
    res_src_e    src;
    logic        sub_sel;
    logic        is_cmp;
    logic_kind_e lkind;
    shift_kind_e skind;

    logic [WIDTH-1:0] arith_res;
    logic             arith_c;
    logic             arith_v;
    logic [WIDTH-1:0] logic_res;
    logic [WIDTH-1:0] shift_res;
    logic             shift_c;

    flags_t flags_q;
    flags_t flags_d;
    logic   flags_we;

    assign op = alu_op_e'(op_sel);

    always_comb begin
        src     = SRC_NONE;
        sub_sel = 1'b0;
        is_cmp  = 1'b0;
        lkind   = LG_AND;
        skind   = SH_LSL;
        dest_we = 1'b1;
        unique case (op)
            OP_ADD: src = SRC_ARITH;
            OP_SUB: begin
                src     = SRC_ARITH;
                sub_sel = 1'b1;
            end
            OP_CMP: begin
                src     = SRC_ARITH;
                sub_sel = 1'b1;
                is_cmp  = 1'b1;
                dest_we = 1'b0;
            end
            OP_AND: begin
                src   = SRC_LOGIC;
                lkind = LG_AND;
            end
            OP_ORR: begin
                src   = SRC_LOGIC;
                lkind = LG_ORR;
            end
            OP_EOR: begin
                src   = SRC_LOGIC;
                lkind = LG_EOR;
            end
            OP_MOV: begin
                src   = SRC_LOGIC;
                lkind = LG_MOV;
            end
            OP_MVN: begin
                src   = SRC_LOGIC;
                lkind = LG_MVN;
            end
            OP_LSL: begin
                src   = SRC_SHIFT;
                skind = SH_LSL;
            end
            OP_LSR: begin
                src   = SRC_SHIFT;
                skind = SH_LSR;
            end
            OP_ASR: begin
                src   = SRC_SHIFT;
                skind = SH_ASR;
            end
            OP_ROR: begin
                src   = SRC_SHIFT;
                skind = SH_ROR;
            end
            default: dest_we = 1'b0;
        endcase
    end

    dp_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i    (opa),
        .b_i    (opb),
        .sub_i  (sub_sel),
        .sum_o  (arith_res),
        .cout_o (arith_c),
        .ovf_o  (arith_v)
    );

    dp_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a_i    (opa),
        .b_i    (opb),
        .kind_i (lkind),
        .res_o  (logic_res)
    );

    dp_alu_shifter #(.WIDTH(WIDTH), .SHW(SHW)) u_shifter (
        .a_i    (opa),
        .amt_i  (shamt),
        .kind_i (skind),
        .cin_i  (flags_q.c),
        .res_o  (shift_res),
        .cout_o (shift_c)
    );

    always_comb begin
        flags_d = flags_q;
        unique case (src)
            SRC_ARITH: begin
                result    = arith_res;
                flags_d.c = arith_c;
                flags_d.v = arith_v;
            end
            SRC_LOGIC: result = logic_res;
            SRC_SHIFT: begin
                result    = shift_res;
                flags_d.c = shift_c;
            end
            default:   result = '0;
        endcase
        flags_d.n = result[MSB];
        flags_d.z = (result == '0);
        flags_we  = (src != SRC_NONE) && (upd_flags || is_cmp);
    end

    dp_alu_flagreg u_flags (
        .clk  (clk),
        .rst  (rst),
        .we_i (flags_we),
        .d_i  (flags_d),
        .q_o  (flags_q)
    );

    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_c = flags_q.c;
    assign flag_v = flags_q.v;

    // R9: compare always loads the zero flag from opa == opb
    p_cmp_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 4'd5) |=> (flag_z == ($past(opa) == $past(opb))));

    // R11: unused codes never touch the flags
    p_unused_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (op_sel >= 4'd12) |=> (flag_n == $past(flag_n) && flag_z == $past(flag_z)
                               && flag_c == $past(flag_c) && flag_v == $past(flag_v)));

    // R7: a flag load reflects the sign of the presented result
    p_neg_r7: assert property (@(posedge clk) disable iff (rst)
        ((op_sel <= 4'd11) && upd_flags) |=> (flag_n == $past(result[MSB])));

endmodule

// File: tb/sim_dp_alu.sv
module sim_dp_alu;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  op_sel;
    logic        upd_flags;
    logic [31:0] opa;
    logic [31:0] opb;
    logic [4:0]  shamt;
    logic [31:0] result;
    logic        dest_we;
    logic        flag_n;
    logic        flag_z;
    logic        flag_c;
    logic        flag_v;

    int checks = 0;
    int fails  = 0;
    logic m_n, m_z, m_c, m_v;

    always #5 clk = ~clk;

    dp_alu u0 (
        .clk       (clk),
        .rst       (rst),
        .op_sel    (op_sel),
        .upd_flags (upd_flags),
        .opa       (opa),
        .opb       (opb),
        .shamt     (shamt),
        .result    (result),
        .dest_we   (dest_we),
        .flag_n    (flag_n),
        .flag_z    (flag_z),
        .flag_c    (flag_c),
        .flag_v    (flag_v)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (op=%0d a=%h b=%h n=%0d)",
                     req, act, exp, op_sel, opa, opb, shamt);
        end
    endtask

    // Reference model, shifts done one bit at a time
    task automatic model(input int op, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] n, input logic cin, input logic vin,
                         output logic [31:0] r, output logic c, output logic v,
                         output logic wr, output logic valid);
        logic [32:0] w;
        c = cin;
        v = vin;
        r = 32'd0;
        valid = (op <= 11);
        wr = valid && (op != 5);
        case (op)
            0: begin
                w = {1'b0, a} + {1'b0, b};
                r = w[31:0];
                c = w[32];
                v = (a[31] == b[31]) && (r[31] != a[31]);
            end
            1, 5: begin
                r = a - b;
                c = (a >= b);
                v = (a[31] != b[31]) && (r[31] != a[31]);
            end
            2: r = a & b;
            3: r = a | b;
            4: r = a ^ b;
            6: r = b;
            7: r = ~b;
            8, 9, 10, 11: begin
                r = a;
                for (int i = 0; i < int'(n); i++) begin
                    if (op == 8) begin
                        c = r[31];
                        r = {r[30:0], 1'b0};
                    end else begin
                        c = r[0];
                        if (op == 9)       r = {1'b0, r[31:1]};
                        else if (op == 10) r = {r[31], r[31:1]};
                        else               r = {r[0], r[31:1]};
                    end
                end
            end
            default: r = 32'd0;
        endcase
    endtask

    task automatic req_of(input int op, output string s);
        case (op)
            0: s = "R1";
            1: s = "R2";
            2, 3, 4, 6, 7: s = "R3";
            5: s = "R9";
            8, 9: s = "R4";
            10, 11: s = "R5";
            default: s = "R11";
        endcase
    endtask

    // One operation: drive at falling edge, check result, check flags next falling edge
    task automatic run_op(input int op, input logic [31:0] a, input logic [31:0] b,
                          input logic [4:0] n, input logic upd);
        logic [31:0] er;
        logic ec, ev, ewr, evalid;
        string rq;
        @(negedge clk);
        op_sel = op[3:0];
        opa = a;
        opb = b;
        shamt = n;
        upd_flags = upd;
        model(op, a, b, n, m_c, m_v, er, ec, ev, ewr, evalid);
        req_of(op, rq);
        if (op >= 8 && op <= 11 && n == 5'd0) rq = "R6";
        #1;
        chk(result == er, rq, result, er);
        chk(dest_we == ewr, (op == 5) ? "R9" : rq, {31'd0, dest_we}, {31'd0, ewr});
        if (evalid && (upd || op == 5)) begin
            m_n = er[31];
            m_z = (er == 32'd0);
            m_c = ec;
            m_v = ev;
        end
        @(negedge clk);
        chk({flag_n, flag_z} == {m_n, m_z}, upd ? "R7" : "R8",
            {30'd0, flag_n, flag_z}, {30'd0, m_n, m_z});
        chk({flag_c, flag_v} == {m_c, m_v}, upd ? rq : "R8",
            {30'd0, flag_c, flag_v}, {30'd0, m_c, m_v});
    endtask

    task automatic do_reset(input logic upd);
        @(negedge clk);
        rst = 1'b1;
        op_sel = 4'd0;
        opa = 32'h7FFF_FFFF;
        opb = 32'd1;
        upd_flags = upd;
        @(negedge clk);
        rst = 1'b0;
        upd_flags = 1'b0;
        {m_n, m_z, m_c, m_v} = 4'b0000;
        chk({flag_n, flag_z, flag_c, flag_v} == 4'b0000, "R10",
            {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'd0);
    endtask

    initial begin
        #(10 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        op_sel = 4'd0;
        upd_flags = 1'b0;
        opa = 32'd0;
        opb = 32'd0;
        shamt = 5'd0;
        {m_n, m_z, m_c, m_v} = 4'b0000;
        repeat (3) @(posedge clk);
        do_reset(1'b1);

        // Directed corners
        run_op(10, 32'd28, 32'd0, 5'd2, 1'b1);          // R5: 28 >> 2 = 7
        run_op(8, 32'd14, 32'd0, 5'd1, 1'b1);           // R4: 14 << 1 = 28
        run_op(0, 32'h7FFF_FFFF, 32'd1, 5'd0, 1'b1);    // R1: positive overflow
        run_op(2, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 5'd0, 1'b1); // R3: keeps V, Z set
        run_op(0, 32'hFFFF_FFFF, 32'd1, 5'd0, 1'b1);    // R1: carry, zero
        run_op(1, 32'h8000_0000, 32'd1, 5'd0, 1'b1);    // R2: negative overflow
        run_op(1, 32'd5, 32'd5, 5'd0, 1'b1);            // R2: equal operands
        run_op(5, 32'd3, 32'd9, 5'd0, 1'b0);            // R9: borrow, no upd needed
        run_op(10, 32'h8000_0000, 32'd0, 5'd4, 1'b1);   // R5: sign fill
        run_op(9, 32'h8000_0001, 32'd0, 5'd1, 1'b1);    // R4: carry from bit 0
        run_op(11, 32'h0000_0001, 32'd0, 5'd1, 1'b1);   // R5: rotate to MSB
        run_op(11, 32'h1234_5678, 32'd0, 5'd0, 1'b1);   // R6: rotate by zero
        run_op(8, 32'h8000_0000, 32'd0, 5'd0, 1'b1);    // R6: shift by zero keeps C
        run_op(8, 32'h0000_0001, 32'd0, 5'd31, 1'b1);   // R4: max amount
        run_op(7, 32'd0, 32'd16, 5'd0, 1'b1);           // R3: move-not
        run_op(6, 32'd0, 32'd0, 5'd0, 1'b0);            // R8: no update
        run_op(13, 32'd0, 32'd0, 5'd0, 1'b1);           // R11: unused code
        do_reset(1'b1);

        // Constrained random
        for (int k = 0; k < 4000; k++) begin
            int op;
            logic [31:0] a, b;
            logic [4:0] n;
            op = $urandom_range(0, 15);
            a = $urandom;
            b = ($urandom_range(0, 7) == 0) ? a : 32'($urandom);
            if ($urandom_range(0, 5) == 0) a = {a[31], 31'h7FFF_FFFF} ^ {1'b0, a[30:0]};
            n = ($urandom_range(0, 5) == 0) ? 5'd0 : 5'($urandom);
            run_op(op, a, b, n, 1'($urandom));
            if (k == 2000) do_reset(1'b1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule